// File: doc/BRIEF.md
# Floating-Point Condition Code Encoder

This unit turns the outcome of a floating-point comparison, or the fields of an 80-bit extended-precision operand, into condition codes. For a comparison it takes a 2-bit relation code (less, equal, greater, unordered), which the comparator produces elsewhere. It writes that relation either into the condition bits of the 16-bit floating-point status word or into the zero, parity and carry bits of a 32-bit integer flags word. For a classification it takes the operand's sign, 15-bit exponent and 64-bit significand, plus a flag saying the register is empty. It reports the operand's class and sign in the status word.

One opcode picks the operation for each input beat. Every field not touched by that operation passes through unchanged. The result is registered and appears one clock after a valid input. The outputs hold their last value while no input is valid.

Top module: `fpcc_encoder`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. While `in_valid` is low, `out_status` and `out_flags` keep their previous values.
- R2: While `rst` is high, `out_valid`, `out_status` and `out_flags` are zero, even if `in_valid` is high.
- R3: Opcode 0 (status compare) uses relation codes 0=less, 1=equal, 2=greater, 3=unordered. It replaces status bits 14, 10 and 8 with 0x0100, 0x4000, 0x0000 or 0x4500 respectively. All other status bits and the whole flags word are passed through.
- R4: Opcode 1 (flags compare) uses flag positions ZF=bit 6, PF=bit 2 and CF=bit 0. It sets CF for less, ZF for equal, none of the three for greater, and all three for unordered. All other flag bits and the whole status word are passed through.
- R5: Opcode 2 (classify) replaces status bits 14, 10, 9 and 8. Bit 9 equals the operand sign. All other status bits and the flags word are passed through.
- R6: For classify with exponent 0x7FFF, a significand of exactly 0x8000000000000000 gives 0x0500 (infinity). Any other significand gives 0x0100 (NaN).
- R7: For classify with exponent 0, a zero significand gives 0x4000 (zero). A nonzero significand gives 0x4400 (denormal).
- R8: For classify with any other exponent, the result is 0x0400 (finite). This holds even when the significand's top bit is clear.
- R9: For classify with `in_empty` high, the result is 0x4100 whatever the exponent and significand are. The sign is still reported in bit 9.
- R10: Opcode 3 (no operation) produces a valid result with status and flags passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_op | input | 2 | Operation: 0 status compare, 1 flags compare, 2 classify, 3 none |
| in_cmp | input | 2 | Relation code: 0 less, 1 equal, 2 greater, 3 unordered |
| in_status | input | 16 | Current floating-point status word |
| in_flags | input | 32 | Current integer flags word |
| in_sign | input | 1 | Operand sign |
| in_exp | input | 15 | Operand biased exponent |
| in_sig | input | 64 | Operand significand including the explicit integer bit |
| in_empty | input | 1 | Operand register is empty |
| out_valid | output | 1 | Result valid |
| out_status | output | 16 | Updated status word |
| out_flags | output | 32 | Updated flags word |

## Verification
Every result is due exactly one rising edge after the cycle in which its input is presented. The driver applies inputs on the falling edge and pushes the expected words into a queue at that time. The monitor samples 1 ns after each rising edge. It pops one expected item whenever `out_valid` is high, and whenever `out_valid` is low it checks that the outputs equal the last result. So a result that comes a cycle early or late, or an output that drifts while idle, shows up as a mismatch.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;

    localparam int SW_W = 16;
    localparam int FL_W = 32;

    localparam int C0_POS = 8;
    localparam int C1_POS = 9;
    localparam int C2_POS = 10;
    localparam int C3_POS = 14;

    typedef enum logic [1:0] {
        OP_SW_CMP = 2'd0,
        OP_FL_CMP = 2'd1,
        OP_CLASS  = 2'd2,
        OP_IDLE   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        REL_LT = 2'd0,
        REL_EQ = 2'd1,
        REL_GT = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    typedef struct packed {
        logic [SW_W-1:0] status;
        logic [FL_W-1:0] flags;
    } result_t;

    typedef struct packed {
        logic c3;
        logic c2;
        logic c1;
        logic c0;
    } cc_t;

    // Place the four condition bits at their status word positions.
    function automatic logic [SW_W-1:0] cc_place(cc_t cc);
        logic [SW_W-1:0] w;
        w = '0;
        w[C3_POS] = cc.c3;
        w[C2_POS] = cc.c2;
        w[C1_POS] = cc.c1;
        w[C0_POS] = cc.c0;
        return w;
    endfunction

    // Overwrite the selected condition bits, keep the rest.
    function automatic logic [SW_W-1:0] cc_merge(logic [SW_W-1:0] base,
                                                 cc_t cc, cc_t sel);
        return (base & ~cc_place(sel)) | (cc_place(cc) & cc_place(sel));
    endfunction

endpackage

// File: rtl/fpcc_sw_cmp.sv
module fpcc_sw_cmp
    import fpcc_pkg::*;
(
    input  rel_e            rel,
    input  logic [SW_W-1:0] sw_in,
    output logic [SW_W-1:0] sw_out
);
    localparam cc_t SEL = '{c3: 1'b1, c2: 1'b1, c1: 1'b0, c0: 1'b1};

    cc_t cc;

    always_comb begin
        cc = '0;
        unique case (rel)
            REL_LT: cc.c0 = 1'b1;
            REL_EQ: cc.c3 = 1'b1;
            REL_GT: cc    = '0;
            REL_UN: begin
                cc.c3 = 1'b1;
                cc.c2 = 1'b1;
                cc.c0 = 1'b1;
            end
            default: cc = '0;
        endcase
    end

    assign sw_out = cc_merge(sw_in, cc, SEL);

endmodule

// File: rtl/fpcc_flag_cmp.sv
module fpcc_flag_cmp
    import fpcc_pkg::*;
#(
    parameter int ZF_BIT = 6,
    parameter int PF_BIT = 2,
    parameter int CF_BIT = 0
) (
    input  rel_e            rel,
    input  logic [FL_W-1:0] fl_in,
    output logic [FL_W-1:0] fl_out
);
    localparam int NFLAG = 3;
    localparam int POS [NFLAG] = '{ZF_BIT, PF_BIT, CF_BIT};

    // set[0]=zero, set[1]=parity, set[2]=carry
    logic [NFLAG-1:0] set;
    logic [FL_W-1:0]  mask;
    logic [FL_W-1:0]  ins;

    always_comb begin
        unique case (rel)
            REL_LT:  set = 3'b100;
            REL_EQ:  set = 3'b001;
            REL_GT:  set = 3'b000;
            REL_UN:  set = 3'b111;
            default: set = 3'b000;
        endcase
    end

    for (genvar g = 0; g < FL_W; g++) begin : g_bit
        always_comb begin
            mask[g] = 1'b0;
            ins[g]  = 1'b0;
            for (int k = 0; k < NFLAG; k++) begin
                if (POS[k] == g) begin
                    mask[g] = 1'b1;
                    ins[g]  = set[k];
                end
            end
        end
    end

    assign fl_out = (fl_in & ~mask) | ins;

endmodule

// File: rtl/fpcc_classify.sv
module fpcc_classify
    import fpcc_pkg::*;
#(
    parameter int EXP_W = 15,
    parameter int SIG_W = 64
) (
    input  logic             sign,
    input  logic [EXP_W-1:0] exp_f,
    input  logic [SIG_W-1:0] sig_f,
    input  logic             empty,
    input  logic [SW_W-1:0]  sw_in,
    output logic [SW_W-1:0]  sw_out
);
    localparam logic [SIG_W-1:0] INT_ONLY = {1'b1, {(SIG_W-1){1'b0}}};
    localparam cc_t SEL = '{c3: 1'b1, c2: 1'b1, c1: 1'b1, c0: 1'b1};

    logic exp_max, exp_zero, sig_zero, sig_int;
    cc_t  cc;

    assign exp_max  = &exp_f;
    assign exp_zero = ~|exp_f;
    assign sig_zero = ~|sig_f;
    assign sig_int  = (sig_f == INT_ONLY);

    always_comb begin
        cc    = '0;
        cc.c1 = sign;
        if (empty) begin
            cc.c3 = 1'b1;
            cc.c0 = 1'b1;
        end else if (exp_max) begin
            cc.c0 = 1'b1;
            cc.c2 = sig_int;
        end else if (exp_zero) begin
            cc.c3 = 1'b1;
            cc.c2 = !sig_zero;
        end else begin
            cc.c2 = 1'b1;
        end
    end

    assign sw_out = cc_merge(sw_in, cc, SEL);

endmodule

// File: rtl/fpcc_encoder.sv
module fpcc_encoder
    import fpcc_pkg::*;
#(
    parameter int EXP_W  = 15,
    parameter int SIG_W  = 64,
    parameter int ZF_BIT = 6,
    parameter int PF_BIT = 2,
    parameter int CF_BIT = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       in_op,
    input  logic [1:0]       in_cmp,
    input  logic [15:0]      in_status,
    input  logic [31:0]      in_flags,
    input  logic             in_sign,
    input  logic [EXP_W-1:0] in_exp,
    input  logic [SIG_W-1:0] in_sig,
    input  logic             in_empty,
    output logic             out_valid,
    output logic [15:0]      out_status,
    output logic [31:0]      out_flags
);
    op_e             op;
    rel_e            rel;
    logic [SW_W-1:0] sw_cmp, sw_cls;
    logic [FL_W-1:0] fl_cmp;
    result_t         res_d, res_q;
    logic            vld_q;

    assign op  = op_e'(in_op);
    assign rel = rel_e'(in_cmp);

    fpcc_sw_cmp u_sw_cmp (
        .rel    (rel),
        .sw_in  (in_status),
        .sw_out (sw_cmp)
    );

    fpcc_flag_cmp #(
        .ZF_BIT (ZF_BIT),
        .PF_BIT (PF_BIT),
        .CF_BIT (CF_BIT)
    ) u_flag_cmp (
        .rel    (rel),
        .fl_in  (in_flags),
        .fl_out (fl_cmp)
    );

    fpcc_classify #(
        .EXP_W (EXP_W),
        .SIG_W (SIG_W)
    ) u_classify (
        .sign   (in_sign),
        .exp_f  (in_exp),
        .sig_f  (in_sig),
        .empty  (in_empty),
        .sw_in  (in_status),
        .sw_out (sw_cls)
    );

    always_comb begin
        res_d.status = in_status;
        res_d.flags  = in_flags;
        unique case (op)
            OP_SW_CMP: res_d.status = sw_cmp;
            OP_FL_CMP: res_d.flags  = fl_cmp;
            OP_CLASS:  res_d.status = sw_cls;
            OP_IDLE:   ;
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                res_q <= res_d;
            end
        end
    end

    assign out_valid  = vld_q;
    assign out_status = res_q.status;
    assign out_flags  = res_q.flags;

endmodule

// File: rtl/fpcc_encoder_chk.sv
module fpcc_encoder_chk #(
    parameter int EXP_W  = 15,
    parameter int SIG_W  = 64,
    parameter int ZF_BIT = 6,
    parameter int PF_BIT = 2,
    parameter int CF_BIT = 0
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [1:0]       in_op,
    input logic [1:0]       in_cmp,
    input logic [15:0]      in_status,
    input logic [31:0]      in_flags,
    input logic             in_sign,
    input logic [EXP_W-1:0] in_exp,
    input logic [SIG_W-1:0] in_sig,
    input logic             in_empty,
    input logic             out_valid,
    input logic [15:0]      out_status,
    input logic [31:0]      out_flags
);
    localparam logic [31:0] ZPC = (32'd1 << ZF_BIT) | (32'd1 << PF_BIT) | (32'd1 << CF_BIT);
    localparam logic [15:0] CMP_BITS = 16'h4500;
    localparam logic [15:0] CLS_BITS = 16'h4700;

    assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_status) && $stable(out_flags)));

    assert_keep_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'd0) |=>
            (((out_status ^ $past(in_status)) & ~CMP_BITS) == 16'h0) &&
            (out_flags == $past(in_flags)));

    assert_unordered_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'd0 && in_cmp == 2'd3) |=>
            ((out_status & CMP_BITS) == CMP_BITS));

    assert_keep_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'd1) |=>
            (out_status == $past(in_status)) &&
            (((out_flags ^ $past(in_flags)) & ~ZPC) == 32'h0));

    assert_ordered_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'd1 && in_cmp != 2'd3) |=>
            ($countones(out_flags & ZPC) <= 1));

    assert_sign_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'd2) |=>
            (out_status[9] == $past(in_sign)) &&
            (((out_status ^ $past(in_status)) & ~CLS_BITS) == 16'h0) &&
            (out_flags == $past(in_flags)));

    assert_empty_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'd2 && in_empty) |=>
            (out_status[14] && out_status[8] && !out_status[10]));

    assert_passthru_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'd3) |=>
            (out_status == $past(in_status)) && (out_flags == $past(in_flags)));

endmodule

bind fpcc_encoder fpcc_encoder_chk #(
    .EXP_W  (EXP_W),
    .SIG_W  (SIG_W),
    .ZF_BIT (ZF_BIT),
    .PF_BIT (PF_BIT),
    .CF_BIT (CF_BIT)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_cmp     (in_cmp),
    .in_status  (in_status),
    .in_flags   (in_flags),
    .in_sign    (in_sign),
    .in_exp     (in_exp),
    .in_sig     (in_sig),
    .in_empty   (in_empty),
    .out_valid  (out_valid),
    .out_status (out_status),
    .out_flags  (out_flags)
);

// File: tb/fpcc_encoder_bench.sv
`timescale 1ns/100ps
module fpcc_encoder_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = 2'd0;
    logic [1:0]  in_cmp = 2'd0;
    logic [15:0] in_status = 16'h0;
    logic [31:0] in_flags = 32'h0;
    logic        in_sign = 1'b0;
    logic [14:0] in_exp = 15'h0;
    logic [63:0] in_sig = 64'h0;
    logic        in_empty = 1'b0;
    logic        out_valid;
    logic [15:0] out_status;
    logic [31:0] out_flags;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0] st;
        logic [31:0] fl;
        string       tag;
    } exp_t;

    exp_t q[$];
    logic [15:0] last_st = 16'h0;
    logic [31:0] last_fl = 32'h0;

    always #2.5 clk = ~clk;

    fpcc_encoder u_fpcc_encoder (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_op      (in_op),
        .in_cmp     (in_cmp),
        .in_status  (in_status),
        .in_flags   (in_flags),
        .in_sign    (in_sign),
        .in_exp     (in_exp),
        .in_sig     (in_sig),
        .in_empty   (in_empty),
        .out_valid  (out_valid),
        .out_status (out_status),
        .out_flags  (out_flags)
    );

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Expected result taken from the requirement text.
    function automatic exp_t expect_of(logic [1:0] op, logic [1:0] cmp,
                                       logic [15:0] st, logic [31:0] fl,
                                       logic sg, logic [14:0] e,
                                       logic [63:0] s, logic emp);
        exp_t r;
        r.st = st;
        r.fl = fl;
        case (op)
            2'd0: begin
                r.tag = "R3";
                case (cmp)
                    2'd0: r.st = (st & ~16'h4500) | 16'h0100;
                    2'd1: r.st = (st & ~16'h4500) | 16'h4000;
                    2'd2: r.st = (st & ~16'h4500);
                    default: r.st = st | 16'h4500;
                endcase
            end
            2'd1: begin
                r.tag = "R4";
                case (cmp)
                    2'd0: r.fl = (fl & ~32'h45) | 32'h01;
                    2'd1: r.fl = (fl & ~32'h45) | 32'h40;
                    2'd2: r.fl = (fl & ~32'h45);
                    default: r.fl = fl | 32'h45;
                endcase
            end
            2'd2: begin
                r.st = (st & ~16'h4700) | (sg ? 16'h0200 : 16'h0000);
                if (emp) begin
                    r.st |= 16'h4100; r.tag = "R9/R5";
                end else if (e == 15'h7fff) begin
                    r.st |= (s == 64'h8000_0000_0000_0000) ? 16'h0500 : 16'h0100;
                    r.tag = "R6/R5";
                end else if (e == 15'h0) begin
                    r.st |= (s == 64'h0) ? 16'h4000 : 16'h4400;
                    r.tag = "R7/R5";
                end else begin
                    r.st |= 16'h0400; r.tag = "R8/R5";
                end
            end
            default: r.tag = "R10";
        endcase
        return r;
    endfunction

    task automatic drive(logic [1:0] op, logic [1:0] cmp, logic [15:0] st,
                         logic [31:0] fl, logic sg, logic [14:0] e,
                         logic [63:0] s, logic emp);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_cmp = cmp; in_status = st;
        in_flags = fl; in_sign = sg; in_exp = e; in_sig = s; in_empty = emp;
        q.push_back(expect_of(op, cmp, st, fl, sg, e, s, emp));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_status = ~in_status;
            in_flags = ~in_flags;
        end
    endtask

    // Monitor: results are due one edge after the input; sample 1 ns later.
    always @(posedge clk) begin
        #1;
        if (!rst && !done) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R1 unexpected valid", 64'(out_valid), 64'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(out_status == e.st, {e.tag, " status"}, 64'(out_status), 64'(e.st));
                    check(out_flags == e.fl, {e.tag, " flags"}, 64'(out_flags), 64'(e.fl));
                end
                last_st = out_status;
                last_fl = out_flags;
            end else begin
                check(out_status == last_st && out_flags == last_fl, "R1 hold",
                      {out_status, out_flags}, {last_st, last_fl});
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R2: valid input during reset must not reach the outputs.
        repeat (2) @(negedge clk);
        in_valid = 1'b1; in_op = 2'd3; in_status = 16'hffff; in_flags = 32'hffff_ffff;
        @(negedge clk);
        check(out_valid == 1'b0 && out_status == 16'h0 && out_flags == 32'h0, "R2 reset",
              {out_valid, out_status, out_flags}, 64'h0);
        in_valid = 1'b0; in_status = 16'h0; in_flags = 32'h0;
        @(negedge clk);
        rst = 1'b0;
        idle(2);
        check(out_valid == 1'b0 && out_status == 16'h0 && out_flags == 32'h0, "R2 after reset",
              {out_valid, out_status, out_flags}, 64'h0);

        // R3: all four relations, status bits set and clear around them.
        for (int c = 0; c < 4; c++) drive(2'd0, 2'(c), 16'hbaff, 32'h1234_5678, 0, 0, 0, 0);
        for (int c = 0; c < 4; c++) drive(2'd0, 2'(c), 16'h0000, 32'hffff_ffff, 0, 0, 0, 0);
        // R4: all four relations, flags all ones and all zeros.
        for (int c = 0; c < 4; c++) drive(2'd1, 2'(c), 16'h5a5a, 32'hffff_ffff, 0, 0, 0, 0);
        for (int c = 0; c < 4; c++) drive(2'd1, 2'(c), 16'ha5a5, 32'h0000_0000, 0, 0, 0, 0);
        idle(3);
        // R6: infinity and NaN (including integer bit clear), both signs.
        drive(2'd2, 0, 16'hffff, 32'h1, 1'b0, 15'h7fff, 64'h8000_0000_0000_0000, 0);
        drive(2'd2, 0, 16'h0000, 32'h2, 1'b1, 15'h7fff, 64'h8000_0000_0000_0000, 0);
        drive(2'd2, 0, 16'h1234, 32'h3, 1'b0, 15'h7fff, 64'hc000_0000_0000_0000, 0);
        drive(2'd2, 0, 16'h1234, 32'h4, 1'b1, 15'h7fff, 64'h0000_0000_0000_0001, 0);
        drive(2'd2, 0, 16'h1234, 32'h4, 1'b0, 15'h7fff, 64'h0, 0);
        // R7: zero and denormal.
        drive(2'd2, 0, 16'hffff, 32'h5, 1'b1, 15'h0, 64'h0, 0);
        drive(2'd2, 0, 16'h0000, 32'h6, 1'b0, 15'h0, 64'h0000_0000_0000_0001, 0);
        drive(2'd2, 0, 16'h0000, 32'h6, 1'b1, 15'h0, 64'h8000_0000_0000_0000, 0);
        // R8: finite, including boundary exponents and integer bit clear.
        drive(2'd2, 0, 16'hffff, 32'h7, 1'b0, 15'h3fff, 64'h8000_0000_0000_0000, 0);
        drive(2'd2, 0, 16'h0000, 32'h7, 1'b1, 15'h0001, 64'h0, 0);
        drive(2'd2, 0, 16'h0000, 32'h7, 1'b0, 15'h7ffe, 64'h7fff_ffff_ffff_ffff, 0);
        // R9: empty overrides every field pattern.
        drive(2'd2, 0, 16'hffff, 32'h8, 1'b1, 15'h7fff, 64'h8000_0000_0000_0000, 1);
        drive(2'd2, 0, 16'h0000, 32'h8, 1'b0, 15'h0, 64'h0, 1);
        drive(2'd2, 0, 16'h0000, 32'h8, 1'b1, 15'h1234, 64'h1, 1);
        // R10: no-operation passes through.
        drive(2'd3, 2'd3, 16'hdead, 32'hcafe_f00d, 1'b1, 15'h0, 64'h0, 1);
        idle(4);
        // Mixed random traffic with idle gaps.
        for (int i = 0; i < 400; i++) begin
            logic [14:0] e;
            logic [63:0] s;
            case ($urandom_range(0, 3))
                0: e = 15'h7fff;
                1: e = 15'h0;
                default: e = 15'($urandom);
            endcase
            case ($urandom_range(0, 2))
                0: s = 64'h0;
                1: s = 64'h8000_0000_0000_0000;
                default: s = {$urandom, $urandom};
            endcase
            drive(2'($urandom), 2'($urandom), 16'($urandom), $urandom,
                  1'($urandom), e, s, ($urandom_range(0, 7) == 0));
            if ($urandom_range(0, 4) == 0) idle($urandom_range(1, 3));
        end
        idle(4);
        check(q.size() == 0, "R1 all results seen", 64'(q.size()), 64'd0);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule